// File: doc/BRIEF.md
# Three-Channel Prescaled Timer Counter

The block holds three independent 16-bit up-counters behind one synchronous register port. All three run from the block clock. Each channel has a power-of-two prescaler, a stop control, a one-shot restart, and a choice of two modes. In free-running mode the count wraps at the top of its range. In interval mode it runs from zero up to a programmed limit and then starts again. Interval wraps, overflows and matches against three compare registers set sticky status bits. A status bit is cleared when software reads the status register. Each channel drives its own interrupt line from its status bits and its enable mask.

The register file is interleaved. Each register kind occupies three consecutive words, one per channel. A channel's register therefore sits one word (4 bytes) away from the same register of the neighbouring channel. Reads are combinational on the address. The read-enable strobe is used only to mark a status read that clears.

Top module: `tri_timer`

## Requirements
- R1: Each counter advances by one on each count tick. In free-running mode it goes from 0xFFFF to 0 and sets status bit 4 (overflow).
- R2: The register kind is the byte address divided by 12, and the channel is (byte address / 4) mod 3. The kinds, in order, are:
  - 0: clock control
  - 1: counter control
  - 2: count (read-only)
  - 3: interval
  - 4 to 6: match 1 to 3
  - 7: status (read-only)
  - 8: interrupt enable

  Writes to the count and status registers are ignored.
- R3: Clock-control bit 0 clear gives one tick per clock. Bit 0 set with field [4:1]=N gives one tick every 2^(N+1) clocks. For example, 0x9 gives one tick every 32 clocks.
- R4: While counter-control bit 0 (stop) is 1, the count holds. After reset every channel is stopped at count 0.
- R5: Writing counter control with bit 4 set puts the count to 0 in that cycle and restarts the prescaler. Bit 4 is not stored and reads back as 0.
- R6: With counter-control bit 1 set, the count runs 0..I, where I is the interval register. The tick at I returns the count to 0 and sets status bit 0.
- R7: With counter-control bit 3 set, a tick that brings the count equal to match register k (k = 1..3) sets status bit k. With bit 3 clear, no match status is raised.
- R8: Status bits are sticky. A read of the status register returns their value and clears them at that clock edge.
- R9: A channel's interrupt line is high exactly when some status bit and the same bit of its 5-bit enable register are both 1. Writing 0 to the enable register masks the line.
- R10: The three channels are independent. A write to one channel's register leaves the others unchanged.
- R11: Counter-control bits 2 and 5 are stored and read back, and they do not change the counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the counters' input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; clears status on a status read |
| addr | input | AW | Byte address of the register |
| wdata | input | W | Write data |
| rdata | output | W | Read data, combinational on addr |
| irq | output | 3 | Per-channel interrupt lines |

## Verification
The hardest state to reach from the ports is the free-running overflow, because it takes a full 65536-tick period. The bench restarts one channel with no prescaling and waits exactly 65535 clocks. It confirms the count reads 0xFFFF with no overflow status, then checks the wrap and the sticky bit one clock later. Interval wraps and matches are reached with small limits. Each of those checks lands on an exact edge counted from the restart write.

// File: rtl/tri_timer.sv
module tri_timer #(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [2:0]    irq
);
  localparam int NCH = 3;
  localparam int PW  = 17;

  logic [4:0]   clk_ctl [NCH];
  logic [5:0]   cnt_ctl [NCH];
  logic [W-1:0] cnt     [NCH];
  logic [W-1:0] intv    [NCH];
  logic [W-1:0] mtch    [NCH][3];
  logic [4:0]   sts     [NCH];
  logic [4:0]   ier     [NCH];
  logic [PW-1:0] pcnt   [NCH];

  logic [PW-1:0] mask [NCH];
  logic [W-1:0]  nxt  [NCH];
  logic [4:0]    ev   [NCH];
  logic [NCH-1:0] tick, rst_w, rd_clr;

  wire [4:0] idx  = addr[6:2];
  wire       ok   = (addr[1:0] == 2'b00) && (addr < AW'(108));
  wire [3:0] kind = 4'(idx / 5'd3);
  wire [1:0] chn  = 2'(idx % 5'd3);
  wire       wr_ok = wr_en && ok;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      logic hit_i, hit_o;
      mask[c]   = clk_ctl[c][0] ? ((PW'(2) << clk_ctl[c][4:1]) - PW'(1)) : '0;
      tick[c]   = !cnt_ctl[c][0] && ((pcnt[c] & mask[c]) == mask[c]);
      hit_i     = cnt_ctl[c][1] && (cnt[c] == intv[c]);
      hit_o     = !hit_i && (cnt[c] == '1);
      nxt[c]    = (hit_i || hit_o) ? '0 : cnt[c] + W'(1);
      rst_w[c]  = wr_ok && kind == 4'd1 && chn == 2'(c) && wdata[4];
      rd_clr[c] = rd_en && ok && kind == 4'd7 && chn == 2'(c);
      ev[c] = '0;
      if (tick[c] && !rst_w[c]) begin
        ev[c][0] = hit_i;
        ev[c][4] = hit_o;
        for (int k = 0; k < 3; k++)
          ev[c][k+1] = cnt_ctl[c][3] && (nxt[c] == mtch[c][k]);
      end
      irq[c] = |(sts[c] & ier[c]);
    end
  end

  always_comb begin
    rdata = '0;
    if (ok) begin
      case (kind)
        4'd0: rdata = W'(clk_ctl[chn]);
        4'd1: rdata = W'(cnt_ctl[chn]);
        4'd2: rdata = cnt[chn];
        4'd3: rdata = intv[chn];
        4'd4: rdata = mtch[chn][0];
        4'd5: rdata = mtch[chn][1];
        4'd6: rdata = mtch[chn][2];
        4'd7: rdata = W'(sts[chn]);
        4'd8: rdata = W'(ier[chn]);
        default: rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) begin
        clk_ctl[c] <= '0;
        cnt_ctl[c] <= 6'h01;
        cnt[c]     <= '0;
        intv[c]    <= '0;
        sts[c]     <= '0;
        ier[c]     <= '0;
        pcnt[c]    <= '0;
        for (int k = 0; k < 3; k++) mtch[c][k] <= '0;
      end else begin
        if (rst_w[c]) begin
          cnt[c]  <= '0;
          pcnt[c] <= '0;
        end else if (!cnt_ctl[c][0]) begin
          pcnt[c] <= pcnt[c] + PW'(1);
          if (tick[c]) cnt[c] <= nxt[c];
        end
        sts[c] <= (rd_clr[c] ? 5'd0 : sts[c]) | ev[c];
        if (wr_ok && chn == 2'(c)) begin
          case (kind)
            4'd0: clk_ctl[c] <= wdata[4:0];
            4'd1: cnt_ctl[c] <= wdata[5:0] & 6'b101111;
            4'd3: intv[c]    <= wdata;
            4'd4: mtch[c][0] <= wdata;
            4'd5: mtch[c][1] <= wdata;
            4'd6: mtch[c][2] <= wdata;
            4'd8: ier[c]     <= wdata[4:0];
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/tri_timer_chk.sv
module tri_timer_chk #(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [W-1:0]  wdata,
  input logic [W-1:0]  cnt [3],
  input logic [4:0]    sts [3],
  input logic [5:0]    cnt_ctl [3],
  input logic [2:0]    irq
);
  wire restart0 = wr_en && addr == AW'(12) && wdata[4];

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[0] != $past(cnt[0])) |-> (cnt[0] == W'($past(cnt[0]) + W'(1)) || cnt[0] == '0));

  // R1
  overflow_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[0][4]) |-> ($past(cnt[0]) == '1 && cnt[0] == '0));

  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ctl[0][0] && !restart0) |=> $stable(cnt[0]));

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart0 |=> cnt[0] == '0);

  // R6
  interval_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[0][0]) |-> cnt[0] == '0);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |-> sts[0] != 5'd0);
endmodule

bind tri_timer tri_timer_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .cnt(cnt), .sts(sts), .cnt_ctl(cnt_ctl), .irq(irq)
);

// File: tb/tri_timer_tb.sv
`timescale 1ns/1ps
module tri_timer_tb;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic [2:0]  irq;
  int checks = 0, failures = 0;

  tri_timer u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                   .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [15:0] v);
    addr = a; #1 v = rdata;
  endtask

  task automatic rd_clear(input logic [7:0] a, output logic [15:0] v);
    addr = a; rd_en = 1; #1 v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    waitn(5);
    for (int c = 0; c < 3; c++) begin
      peek(8'h18 + 8'(4*c), v); check("R4 reset count held", v, 16'h0);
    end
    peek(8'h0C, v); check("R4 reset stop bit", v, 16'h0001);
    check("R9 reset irq", 16'(irq), 16'h0);
  endtask

  task automatic t_free();
    logic [15:0] v;
    wr(8'h0C, 16'h0010);
    waitn(5); peek(8'h18, v); check("R1 free count", v, 16'd5);
  endtask

  task automatic t_stored_bits();
    logic [15:0] v;
    wr(8'h0C, 16'h0034);
    peek(8'h0C, v); check("R5 R11 ctl readback", v, 16'h0024);
    waitn(3); peek(8'h18, v); check("R11 counts up with bits 2,5", v, 16'd3);
  endtask

  task automatic t_prescale();
    logic [15:0] v;
    wr(8'h00, 16'h0009);
    wr(8'h0C, 16'h0010);
    waitn(31); peek(8'h18, v); check("R3 div32 before tick", v, 16'd0);
    waitn(1);  peek(8'h18, v); check("R3 div32 first tick", v, 16'd1);
    waitn(32); peek(8'h18, v); check("R3 div32 second tick", v, 16'd2);
    wr(8'h00, 16'h0001);
    wr(8'h0C, 16'h0010);
    waitn(1); peek(8'h18, v); check("R3 div2 hold", v, 16'd0);
    waitn(1); peek(8'h18, v); check("R3 div2 tick", v, 16'd1);
    waitn(2); peek(8'h18, v); check("R3 div2 next", v, 16'd2);
    wr(8'h00, 16'h0000);
  endtask

  task automatic t_stop_readonly();
    logic [15:0] v, v2, s;
    wr(8'h0C, 16'h0001);
    peek(8'h18, v); waitn(10); peek(8'h18, v2);
    check("R4 stopped count holds", v2, v);
    peek(8'h54, s);
    wr(8'h18, 16'h1234); peek(8'h18, v2); check("R2 count write ignored", v2, v);
    wr(8'h54, 16'h001F); peek(8'h54, v2); check("R2 status write ignored", v2, s);
    wr(8'h28, 16'hABCD);
    peek(8'h28, v2); check("R2 ch1 interval at +4", v2, 16'hABCD);
    peek(8'h24, v2); check("R10 ch0 interval untouched", v2, 16'h0000);
    peek(8'h2C, v2); check("R10 ch2 interval untouched", v2, 16'h0000);
  endtask

  task automatic t_interval();
    logic [15:0] v;
    wr(8'h2C, 16'd3);
    wr(8'h68, 16'h0001);
    wr(8'h14, 16'h0012);
    waitn(3); peek(8'h20, v); check("R6 reaches interval", v, 16'd3);
    peek(8'h5C, v); check("R6 no status before wrap", v, 16'h0);
    check("R9 irq low before wrap", 16'(irq[2]), 16'h0);
    waitn(1); peek(8'h20, v); check("R6 wraps to 0", v, 16'd0);
    peek(8'h5C, v); check("R6 interval status", v, 16'h0001);
    check("R9 irq2 high", 16'(irq[2]), 16'h1);
    check("R10 irq0 quiet", 16'(irq[0]), 16'h0);
    rd_clear(8'h5C, v); check("R8 read returns status", v, 16'h0001);
    peek(8'h5C, v); check("R8 status cleared", v, 16'h0);
    check("R9 irq2 low after clear", 16'(irq[2]), 16'h0);
    wr(8'h14, 16'h0001);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    wr(8'h10, 16'h0010);
    waitn(65535); peek(8'h1C, v); check("R1 count at top", v, 16'hFFFF);
    peek(8'h58, v); check("R1 no overflow yet", v, 16'h0);
    waitn(1); peek(8'h1C, v); check("R1 wraps to 0", v, 16'h0);
    peek(8'h58, v); check("R1 overflow status", v, 16'h0010);
  endtask

  task automatic t_match();
    logic [15:0] v;
    wr(8'h40, 16'd7);
    rd_clear(8'h58, v); check("R8 sticky overflow read", v, 16'h0010);
    wr(8'h10, 16'h0010);
    waitn(7); peek(8'h58, v); check("R7 no match when disabled", v, 16'h0);
    wr(8'h10, 16'h0018);
    waitn(6); peek(8'h58, v); check("R7 no match before 7", v, 16'h0);
    waitn(1); peek(8'h1C, v); check("R7 count at match", v, 16'd7);
    peek(8'h58, v); check("R7 match2 status", v, 16'h0004);
    check("R9 irq1 low with enable 0", 16'(irq[1]), 16'h0);
    wr(8'h64, 16'h0004);
    check("R9 irq1 high on enabled match", 16'(irq[1]), 16'h1);
    wr(8'h64, 16'h0000);
    check("R9 irq1 masked", 16'(irq[1]), 16'h0);
    peek(8'h58, v); check("R8 status still set while masked", v, 16'h0004);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_free();
    t_stored_bits();
    t_prescale();
    t_stop_readonly();
    t_interval();
    t_wrap();
    t_match();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule